// File: doc/BRIEF.md
# Transmit Character-Type Decoder with Word-Sync Sequencer

This block sits in front of an 8b/10b encoder on the transmit side of a serial link. On every character clock it samples one data byte, two control bits, an optional special-character select bit and a parity-error flag. From these inputs it chooses what the encoder should emit next: an ordinary data character, a K28.5 fill comma, a special character taken from the data byte, or a 16-character word-synchronization sequence. It produces a byte, a flag that marks the byte as a control character, and a class tag. The encoder uses the flag and the tag to pick its code table.

A static mode input chooses between two decode variants. In one variant the select bit takes part in the decode. In the other the select bit is ignored and both control bits are used. A word-sync sequence cannot be interrupted by the control inputs once it has started. Only a qualified parity error can stop it, and that error also forces a violation symbol onto the output. A qualified parity error at any other time replaces just that one character with the violation symbol.

Top module: `txCharSequencer`

## Requirements
- R1: Each output is registered. The output that follows a rising clock edge reflects the inputs sampled at that edge, so there is one cycle of latency.
- R2: When the no-select mode is active (`useSel`=0), control 00 gives the data byte with `encIsCtrl`=0 and class 0. In the select mode, `txSel`=0 together with `txCtrl[0]`=0 gives the same result.
- R3: In the no-select mode, control 01 gives the fill comma 0xBC with `encIsCtrl`=1 and class 1. In the select mode, `txSel`=0 with `txCtrl[0]`=1 gives the same fill.
- R4: In the no-select mode, control 10 gives a special character. The data byte passes through unchanged with `encIsCtrl`=1 and class 2. In the select mode, `txSel`=1 with `txCtrl[0]`=0 gives the same special character.
- R5: In the no-select mode, a sync sequence starts only when control is 11, and `txSel` has no effect.
- R6: In the select mode, a sync sequence starts only when `txSel` and `txCtrl[0]` are both high, and `txCtrl[1]` has no effect.
- R7: A sync sequence is 16 characters long. The first is 0xBC with `encIsCtrl`=1 and class 3. It is followed by entries i=1..15, where entry i is the byte {i[3:0], ~i[3:0]}, each with `encIsCtrl`=0 and class 4. The control and select inputs have no effect while the sequence runs.
- R8: A qualified parity error during a sync sequence outputs the violation symbol C0.7 (0xE0, `encIsCtrl`=1, class 5) and ends the sequence, whatever the control bits are. A new sequence may start on the very next character.
- R9: A qualified parity error outside a sync sequence replaces only that character with the violation symbol. It also stops a start condition in that same cycle from starting a sequence.
- R10: A parity error is qualified only while `parityEn` is high. When `parityEn` is low, the `parityErr` flag has no effect.
- R11: A synchronous active-low reset drives the output to byte 0, `encIsCtrl`=0 and class 0, and returns the sequencer to idle. The first character after reset is decoded from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Synchronous active-low reset |
| useSel | input | 1 | Static mode: 1 = the select bit takes part in the decode |
| parityEn | input | 1 | Enables checking of the parity-error flag |
| txData | input | 8 | Transmit data byte |
| txCtrl | input | 2 | Character-type control bits |
| txSel | input | 1 | Special-character select bit |
| parityErr | input | 1 | Parity error seen on this character |
| encData | output | 8 | Byte passed to the encoder |
| encIsCtrl | output | 1 | 1 = the encoder should use its control-code table |
| encClass | output | 3 | Class tag: 0 data, 1 fill, 2 special, 3 sync comma, 4 sync data, 5 violation |

## Verification
The hardest case to reach is a parity error that arrives at a chosen depth inside a running sync sequence, followed at once by a new start. The bench reaches it by starting a sequence and counting characters in its own model. It raises the parity flag at a chosen index while the control bits ask for something else, then applies the start condition on the next character. A full sweep over mode, parity enable, control, select, parity flag and data also lands on many sequence starts and aborts at arbitrary points, and the reference model follows each of them.

// File: rtl/txSeqPkg.sv
package txSeqPkg;
  localparam int SEQ_LEN   = 16;
  localparam int SEQ_IDX_W = $clog2(SEQ_LEN);

  typedef enum logic [2:0] {
    CLS_DATA       = 3'd0,
    CLS_FILL       = 3'd1,
    CLS_SPECIAL    = 3'd2,
    CLS_SYNC_COMMA = 3'd3,
    CLS_SYNC_DATA  = 3'd4,
    CLS_VIOL       = 3'd5
  } charClassE;

  typedef struct packed {
    logic                 pickData;
    logic                 pickFill;
    logic                 pickSpecial;
    logic                 pickComma;
    logic                 pickSeq;
    logic                 pickViol;
    logic [SEQ_IDX_W-1:0] seqIdx;
  } strobeS;
endpackage

// File: rtl/txSeqCtrl.sv
module txSeqCtrl
  import txSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       useSel,
  input  logic       parityEn,
  input  logic [1:0] txCtrl,
  input  logic       txSel,
  input  logic       parityErr,
  output strobeS     strobes
);
  localparam logic [SEQ_IDX_W-1:0] LAST_IDX = SEQ_IDX_W'(SEQ_LEN - 1);
  localparam logic [SEQ_IDX_W-1:0] FIRST_IDX = SEQ_IDX_W'(1);

  logic                 seqActive, seqActiveNext;
  logic [SEQ_IDX_W-1:0] seqCnt, seqCntNext;
  logic                 badChar;
  logic                 startReq;
  logic [1:0]           typeCode;

  assign badChar = parityEn & parityErr;

  // Normalize both modes onto one 2-bit type code: 0 data, 1 fill, 2 special, 3 sync
  always_comb begin
    if (useSel) typeCode = {txSel, txCtrl[0]};
    else        typeCode = txCtrl;
  end

  assign startReq = (typeCode == 2'b11);

  always_comb begin
    strobes       = '0;
    seqActiveNext = seqActive;
    seqCntNext    = seqCnt;
    if (seqActive) begin
      if (badChar) begin
        strobes.pickViol = 1'b1;
        seqActiveNext    = 1'b0;
      end else begin
        strobes.pickSeq = 1'b1;
        strobes.seqIdx  = seqCnt;
        if (seqCnt == LAST_IDX) seqActiveNext = 1'b0;
        else                    seqCntNext    = seqCnt + 1'b1;
      end
    end else if (badChar) begin
      strobes.pickViol = 1'b1;
    end else if (startReq) begin
      strobes.pickComma = 1'b1;
      seqActiveNext     = 1'b1;
      seqCntNext        = FIRST_IDX;
    end else begin
      unique case (typeCode)
        2'b00:   strobes.pickData    = 1'b1;
        2'b01:   strobes.pickFill    = 1'b1;
        default: strobes.pickSpecial = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqActive <= 1'b0;
      seqCnt    <= '0;
    end else begin
      seqActive <= seqActiveNext;
      seqCnt    <= seqCntNext;
    end
  end
endmodule

// File: rtl/txSeqDatapath.sv
module txSeqDatapath
  import txSeqPkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] FILL_CODE = 8'hBC,
  parameter logic [DATA_W-1:0] VIOL_CODE = 8'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobes,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] encData,
  output logic              encIsCtrl,
  output logic [2:0]        encClass
);
  localparam logic [DATA_W-1:0] ROM_MASK = DATA_W'((1 << SEQ_IDX_W) - 1);

  function automatic logic [DATA_W-1:0] romEntry(input int idx);
    romEntry = DATA_W'(idx * ((1 << SEQ_IDX_W) + 1)) ^ ROM_MASK;
  endfunction

  logic [DATA_W-1:0] seqRom [SEQ_LEN];

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_rom
    assign seqRom[g] = romEntry(g);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encData   <= '0;
      encIsCtrl <= 1'b0;
      encClass  <= CLS_DATA;
    end else if (strobes.pickViol) begin
      encData   <= VIOL_CODE;
      encIsCtrl <= 1'b1;
      encClass  <= CLS_VIOL;
    end else if (strobes.pickComma) begin
      encData   <= FILL_CODE;
      encIsCtrl <= 1'b1;
      encClass  <= CLS_SYNC_COMMA;
    end else if (strobes.pickSeq) begin
      encData   <= seqRom[strobes.seqIdx];
      encIsCtrl <= 1'b0;
      encClass  <= CLS_SYNC_DATA;
    end else if (strobes.pickFill) begin
      encData   <= FILL_CODE;
      encIsCtrl <= 1'b1;
      encClass  <= CLS_FILL;
    end else if (strobes.pickSpecial) begin
      encData   <= txData;
      encIsCtrl <= 1'b1;
      encClass  <= CLS_SPECIAL;
    end else begin
      encData   <= txData;
      encIsCtrl <= 1'b0;
      encClass  <= CLS_DATA;
    end
  end
endmodule

// File: rtl/txCharSequencer.sv
module txCharSequencer
  import txSeqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              useSel,
  input  logic              parityEn,
  input  logic [DATA_W-1:0] txData,
  input  logic [1:0]        txCtrl,
  input  logic              txSel,
  input  logic              parityErr,
  output logic [DATA_W-1:0] encData,
  output logic              encIsCtrl,
  output logic [2:0]        encClass
);
  strobeS strobes;

  txSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .useSel    (useSel),
    .parityEn  (parityEn),
    .txCtrl    (txCtrl),
    .txSel     (txSel),
    .parityErr (parityErr),
    .strobes   (strobes)
  );

  txSeqDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .txData    (txData),
    .encData   (encData),
    .encIsCtrl (encIsCtrl),
    .encClass  (encClass)
  );
endmodule

// File: rtl/txSeqChecker.sv
module txSeqChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              useSel,
  input logic              parityEn,
  input logic [DATA_W-1:0] txData,
  input logic [1:0]        txCtrl,
  input logic              txSel,
  input logic              parityErr,
  input logic [DATA_W-1:0] encData,
  input logic              encIsCtrl,
  input logic [2:0]        encClass
);
  // R8 / R9: a qualified parity error gives the violation symbol next cycle
  assert_viol_on_parity_R8: assert property (@(posedge clk) disable iff (!rstN)
    (parityEn && parityErr) |=> (encClass == 3'd5 && encData == 8'hE0 && encIsCtrl));

  // R7: a sync comma is followed by sequence data unless a parity error intervenes
  assert_comma_then_seq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (encClass == 3'd3 && !(parityEn && parityErr)) |=> (encClass == 3'd4));

  // R3: every fill output carries the comma code as a control character
  assert_fill_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (encClass == 3'd1) |-> (encData == 8'hBC && encIsCtrl));

  // R2: data in no-select mode with control 00 and no parity error passes through
  assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!useSel && txCtrl == 2'b00 && !(parityEn && parityErr) && encClass != 3'd3 && encClass != 3'd4)
    |=> (encClass == 3'd0 && !encIsCtrl && encData == $past(txData)));

  // R10: an unqualified parity flag never produces a violation
  assert_parity_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!parityEn) |=> (encClass != 3'd5));

  // R11: reset clears the output
  assert_reset_out_R11: assert property (@(posedge clk)
    (rstN && $past(!rstN)) |-> (encData == '0 && !encIsCtrl && encClass == 3'd0));
endmodule

bind txCharSequencer txSeqChecker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .useSel    (useSel),
  .parityEn  (parityEn),
  .txData    (txData),
  .txCtrl    (txCtrl),
  .txSel     (txSel),
  .parityErr (parityErr),
  .encData   (encData),
  .encIsCtrl (encIsCtrl),
  .encClass  (encClass)
);

// File: tb/txCharSequencer_tb.sv
module txCharSequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       useSel = 1'b0;
  logic       parityEn = 1'b0;
  logic [7:0] txData = '0;
  logic [1:0] txCtrl = '0;
  logic       txSel = 1'b0;
  logic       parityErr = 1'b0;
  logic [7:0] encData;
  logic       encIsCtrl;
  logic [2:0] encClass;

  int checks = 0;
  int errors = 0;
  bit mActive = 0;
  int mCnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txCharSequencer u_dut (
    .clk(clk), .rstN(rstN), .useSel(useSel), .parityEn(parityEn),
    .txData(txData), .txCtrl(txCtrl), .txSel(txSel), .parityErr(parityErr),
    .encData(encData), .encIsCtrl(encIsCtrl), .encClass(encClass)
  );

  // R1: drive at negedge, sample one time unit after the next posedge
  task automatic step(input logic r, input logic m, input logic pe, input logic [1:0] c,
                      input logic s, input logic [7:0] d, input logic e, input string note);
    logic [7:0] xData;
    logic       xCtrl;
    logic [2:0] xCls;
    string      tag;
    logic [1:0] code;
    @(negedge clk);
    rstN = r; useSel = m; parityEn = pe; txCtrl = c; txSel = s; txData = d; parityErr = e;
    code = m ? {s, c[0]} : c;
    if (!r) begin
      xData = 0; xCtrl = 0; xCls = 0; mActive = 0; tag = "R11";
    end else if (mActive) begin
      if (pe && e) begin
        xData = 8'hE0; xCtrl = 1; xCls = 5; mActive = 0; tag = "R8";
      end else begin
        xData = {mCnt[3:0], ~mCnt[3:0]}; xCtrl = 0; xCls = 4; tag = "R7";
        if (mCnt == 15) mActive = 0; else mCnt++;
      end
    end else if (pe && e) begin
      xData = 8'hE0; xCtrl = 1; xCls = 5; tag = "R9";
    end else if (code == 2'b11) begin
      xData = 8'hBC; xCtrl = 1; xCls = 3; mActive = 1; mCnt = 1;
      tag = m ? "R6" : "R5";
    end else if (code == 2'b00) begin
      xData = d; xCtrl = 0; xCls = 0; tag = "R2";
    end else if (code == 2'b01) begin
      xData = 8'hBC; xCtrl = 1; xCls = 1; tag = "R3";
    end else begin
      xData = d; xCtrl = 1; xCls = 2; tag = "R4";
    end
    if (!pe && e && r) tag = {tag, "/R10"};
    @(posedge clk);
    #1;
    checks++;
    if (encData !== xData || encIsCtrl !== xCtrl || encClass !== xCls) begin
      errors++;
      $display("FAIL %s %s: got data=%h ctrl=%b cls=%0d expected data=%h ctrl=%b cls=%0d",
               tag, note, encData, encIsCtrl, encClass, xData, xCtrl, xCls);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] dv [3];
    dv[0] = 8'h00; dv[1] = 8'h5A; dv[2] = 8'hFF;

    // R11: reset state
    step(0, 0, 0, 2'b01, 0, 8'h33, 0, "reset");
    step(0, 0, 0, 2'b10, 1, 8'h44, 1, "reset hold");

    // Near-exhaustive sweep (R2..R10)
    for (int m = 0; m < 2; m++)
      for (int pe = 0; pe < 2; pe++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
              for (int k = 0; k < 3; k++)
                step(1, m[0], pe[0], c[1:0], s[0], dv[k] ^ 8'(c*16 + s*4 + e), e[0], "sweep");

    // R11: reset mid-sequence, then decode from inputs immediately
    step(1, 0, 1, 2'b11, 0, 8'h00, 0, "R5 start");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 2'b00, 0, 8'h12, 0, "R7 run");
    step(0, 0, 1, 2'b11, 0, 8'h00, 0, "R11 reset in seq");
    step(1, 0, 1, 2'b10, 0, 8'h7C, 0, "R11 first after reset");

    // R7: full atomic sequence with hostile controls, then immediate restart
    step(1, 0, 1, 2'b11, 1, 8'h00, 0, "R5 start");
    for (int i = 1; i < 16; i++) step(1, 0, 1, 2'(i), i[0], 8'(i * 7), 0, "R7 atomic");
    step(1, 0, 1, 2'b11, 0, 8'h00, 0, "R5 restart after last");
    for (int i = 1; i < 16; i++) step(1, 0, 1, 2'b11, 0, 8'h00, 0, "R7 second pass");

    // R8: abort at index 7 in select mode, restart on the next character
    step(1, 1, 1, 2'b01, 1, 8'h00, 0, "R6 start");
    for (int i = 1; i < 7; i++) step(1, 1, 1, 2'b00, 0, 8'h21, 0, "R7 run");
    step(1, 1, 1, 2'b00, 0, 8'h21, 1, "R8 abort");
    step(1, 1, 1, 2'b11, 1, 8'h00, 0, "R8 restart");
    step(1, 1, 1, 2'b00, 0, 8'h00, 0, "R7 first entry");

    // R10: flag ignored inside a sequence when parity checking is off
    step(1, 0, 0, 2'b01, 0, 8'h00, 1, "R10 in seq");
    for (int i = 0; i < 15; i++) step(1, 0, 0, 2'b00, 0, 8'h99, 1, "R10 in seq");

    // R9: parity error suppresses a start
    step(1, 1, 1, 2'b11, 1, 8'h00, 1, "R9 start blocked");
    step(1, 1, 1, 2'b00, 0, 8'hA5, 0, "R9 no sequence");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule